// File: doc/BRIEF.md
# Warp Load Sector Coalescer

This block sits between the load path of a 32-lane SIMT core and a memory interface that only serves aligned 32-byte sectors. It accepts one warp-wide load: a byte address for every lane plus a mask of the lanes that take part. It reduces the active addresses to the set of distinct sectors that hold the requested words, and sends each sector address out once, one per handshake. Sector data comes back in the order the fetches went out. The block copies each lane's 4-byte word out of the returned sector into that lane's slot.

When the last sector has been scattered, the block raises a one-cycle completion pulse. With the pulse it gives the number of sectors fetched and the number of bytes the lanes asked for. A neighbouring unit can use these two values to judge how well the access used the bus. For example, a fully coalesced warp moves 128 useful bytes in 4 sectors, and a scattered warp moves the same 128 bytes in 32 sectors (1024 bytes on the bus).

Every active lane must give a word-aligned address. If any active lane does not, the request is refused with an error flag and no fetch is issued.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `fetch_valid` is 0, `done` is 0, and `lane_data`, `sector_count` and `useful_bytes` are all 0.
- R2: Each fetch address is a multiple of 32, and a request issues one fetch for each distinct sector (address divided by 32) among its active lanes, with no repeats and nothing else.
- R3: Fetches are issued in ascending order of the lowest-numbered active lane that touches each sector. While `fetch_valid` is 1 and `fetch_ready` is 0, `fetch_addr` holds steady.
- R4: With all 32 lanes active and lane i reading base+4i, for a 128-byte-aligned base, the request issues exactly 4 fetches and reports 128 useful bytes.
- R5: With all 32 lanes active and lane i reading base+32i, the request issues 32 fetches (1024 bytes fetched) for 128 useful bytes.
- R6: Inactive lanes add no fetch and no useful bytes. With only lanes 0..3 active on contiguous words, exactly 1 fetch is issued. With an all-zero mask, there is no fetch, and `done` pulses with counts of 0.
- R7: If any active lane has address bits [1:0] nonzero, `done` pulses with `err`=1, `sector_count`=0 and `useful_bytes`=0, and no fetch is issued. A misaligned address on an inactive lane is ignored.
- R8: Responses return in fetch order. In `resp_data`, the word at byte offset 4k of the sector sits in bits [32k+31:32k]. Each active lane gets, in `lane_data` bits [32i+31:32i], the word of its own sector at offset (address mod 32). Inactive lanes read 0.
- R9: `done` is high for exactly one cycle, in the cycle after the last response is taken. It comes with `sector_count` equal to the number of fetches and `useful_bytes` equal to 4 times the number of active lanes. `req_ready` is 0 from acceptance until `done`, and 1 when `done` is high.
- R10: Lanes that read the same word, or different words of one sector, are all served from a single fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_addr | input | LANES*ADDR_W | Byte address per lane, lane i in bits [ADDR_W*i +: ADDR_W] |
| req_mask | input | LANES | Active-lane mask |
| fetch_valid | output | 1 | Sector fetch offered |
| fetch_ready | input | 1 | Memory side takes the fetch |
| fetch_addr | output | ADDR_W | Sector-aligned fetch address |
| resp_valid | input | 1 | Sector data returned (in fetch order) |
| resp_data | input | SECTOR_BYTES*8 | Returned sector contents |
| lane_data | output | LANES*WORD_BYTES*8 | Scattered word per lane |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Misaligned active lane flagged on this completion |
| sector_count | output | $clog2(LANES+1) | Sectors fetched for the request |
| useful_bytes | output | $clog2(LANES*WORD_BYTES+1) | Bytes requested by active lanes |

## Verification
A broken duplicate filter shows up within the first few fetch handshakes of a request: a sector address comes out twice, or one is missing, or they come out in the wrong order, and the final count is off. If the pending bookkeeping for responses goes wrong, the wrong lanes receive a sector's words. That shows as bad `lane_data` at the completion pulse, or as a pulse that comes too early or never comes. Alignment mistakes show in the same cycle that the request leaves its preparation step: fetches appear on a request that should have been refused, or a valid request is refused.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } coal_state_e;
endpackage

// File: rtl/sector_dedup.sv
module sector_dedup #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4
) (
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES-1:0]        mask,
  output logic [LANES-1:0]        first,
  output logic                    misalign
);
  localparam int SEC_OFF_W  = $clog2(SECTOR_BYTES);
  localparam int WORD_OFF_W = $clog2(WORD_BYTES);
  localparam int SEC_W      = ADDR_W - SEC_OFF_W;

  logic [LANES-1:0] bad;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEC_W-1:0] my_sec;
    logic             seen;
    assign my_sec = addr[i*ADDR_W+SEC_OFF_W +: SEC_W];
    assign bad[i] = mask[i] && (addr[i*ADDR_W +: WORD_OFF_W] != '0);
    // a lane leads its sector only if no lower active lane already touches it
    always_comb begin
      seen = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (mask[j] && (addr[j*ADDR_W+SEC_OFF_W +: SEC_W] == my_sec)) seen = 1'b1;
      end
    end
    assign first[i] = mask[i] && !seen;
  end

  assign misalign = |bad;
endmodule

// File: rtl/lead_pick.sv
module lead_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any   = |req;
  assign grant = any ? (N'(1) << idx) : '0;
endmodule

// File: rtl/lane_scatter.sv
module lane_scatter #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4
) (
  input  logic [LANES*ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]                mask,
  input  logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] lead_sec,
  input  logic [SECTOR_BYTES*8-1:0]       sec_data,
  output logic [LANES-1:0]                hit,
  output logic [LANES*WORD_BYTES*8-1:0]   words
);
  localparam int SEC_OFF_W  = $clog2(SECTOR_BYTES);
  localparam int WORD_OFF_W = $clog2(WORD_BYTES);
  localparam int SEL_W      = SEC_OFF_W - WORD_OFF_W;
  localparam int SEC_W      = ADDR_W - SEC_OFF_W;
  localparam int WBITS      = WORD_BYTES * 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel    = addr[i*ADDR_W+WORD_OFF_W +: SEL_W];
    assign hit[i] = mask[i] && (addr[i*ADDR_W+SEC_OFF_W +: SEC_W] == lead_sec);
    assign words[i*WBITS +: WBITS] = sec_data[sel*WBITS +: WBITS];
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [LANES*ADDR_W-1:0]                  req_addr,
  input  logic [LANES-1:0]                         req_mask,
  output logic                                     fetch_valid,
  input  logic                                     fetch_ready,
  output logic [ADDR_W-1:0]                        fetch_addr,
  input  logic                                     resp_valid,
  input  logic [SECTOR_BYTES*8-1:0]                resp_data,
  output logic [LANES*WORD_BYTES*8-1:0]            lane_data,
  output logic                                     done,
  output logic                                     err,
  output logic [$clog2(LANES+1)-1:0]               sector_count,
  output logic [$clog2(LANES*WORD_BYTES+1)-1:0]    useful_bytes
);
  localparam int SEC_OFF_W = $clog2(SECTOR_BYTES);
  localparam int SEC_W     = ADDR_W - SEC_OFF_W;
  localparam int IW        = $clog2(LANES);
  localparam int CNT_W     = $clog2(LANES + 1);
  localparam int BYTES_W   = $clog2(LANES * WORD_BYTES + 1);
  localparam int WBITS     = WORD_BYTES * 8;

  coal_state_e           state;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]      mask_q;
  logic [LANES-1:0]      issue_pend;
  logic [LANES-1:0]      resp_pend;

  logic [LANES-1:0]      first_w;
  logic                  misalign_w;
  logic [LANES-1:0]      iss_grant, rsp_grant;
  logic [IW-1:0]         iss_idx, rsp_idx;
  logic                  iss_any, rsp_any;
  logic [LANES-1:0]      hit_w;
  logic [LANES*WBITS-1:0] words_w;
  logic [SEC_W-1:0]      iss_sec, rsp_sec;

  sector_dedup #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_dedup (
    .addr(addr_q), .mask(mask_q), .first(first_w), .misalign(misalign_w)
  );

  lead_pick #(.N(LANES)) u_iss_pick (
    .req(issue_pend), .grant(iss_grant), .idx(iss_idx), .any(iss_any)
  );

  lead_pick #(.N(LANES)) u_rsp_pick (
    .req(resp_pend), .grant(rsp_grant), .idx(rsp_idx), .any(rsp_any)
  );

  assign iss_sec = addr_q[iss_idx*ADDR_W+SEC_OFF_W +: SEC_W];
  assign rsp_sec = addr_q[rsp_idx*ADDR_W+SEC_OFF_W +: SEC_W];

  lane_scatter #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_scatter (
    .addr(addr_q), .mask(mask_q), .lead_sec(rsp_sec), .sec_data(resp_data),
    .hit(hit_w), .words(words_w)
  );

  assign req_ready   = (state == ST_IDLE);
  assign fetch_valid = (state == ST_RUN) && iss_any;
  assign fetch_addr  = {iss_sec, {SEC_OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      addr_q       <= '0;
      mask_q       <= '0;
      issue_pend   <= '0;
      resp_pend    <= '0;
      lane_data    <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
      sector_count <= '0;
      useful_bytes <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            mask_q <= req_mask;
            state  <= ST_PREP;
          end
        end
        ST_PREP: begin
          lane_data <= '0;
          err       <= misalign_w;
          if (misalign_w) begin
            sector_count <= '0;
            useful_bytes <= '0;
            done         <= 1'b1;
            state        <= ST_IDLE;
          end else begin
            sector_count <= CNT_W'($countones(first_w));
            useful_bytes <= BYTES_W'($countones(mask_q) * WORD_BYTES);
            if (first_w == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              issue_pend <= first_w;
              resp_pend  <= first_w;
              state      <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (fetch_valid && fetch_ready) issue_pend <= issue_pend & ~iss_grant;
          if (resp_valid && rsp_any) begin
            resp_pend <= resp_pend & ~rsp_grant;
            for (int i = 0; i < LANES; i++) begin
              if (hit_w[i]) lane_data[i*WBITS +: WBITS] <= words_w[i*WBITS +: WBITS];
            end
            if ((resp_pend & ~rsp_grant) == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a stalled fetch keeps its address until taken
  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  // R8: every sector not yet fetched is still awaiting its response
  p_pend_subset_r8: assert property (@(posedge clk) disable iff (rst)
    ((issue_pend & ~resp_pend) == '0));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: the block is idle again when completion is reported
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R2: no fetch is offered while the block takes new requests
  p_fetch_busy_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> !req_ready);

  // R7: an error completion never carries a sector count
  p_err_nocount_r7: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (sector_count == '0));
endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES*32-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic fetch_valid;
  logic fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic resp_valid = 1'b0;
  logic [255:0] resp_data = '0;
  logic [LANES*32-1:0] lane_data;
  logic done, err;
  logic [5:0] sector_count;
  logic [7:0] useful_bytes;

  warp_coalescer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .resp_valid(resp_valid),
    .resp_data(resp_data), .lane_data(lane_data), .done(done), .err(err),
    .sector_count(sector_count), .useful_bytes(useful_bytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit stall_mode = 1'b0;
  logic [31:0] got_fetch [256];
  int got_n = 0;
  int rsp_ptr = 0;
  logic [31:0] a [LANES];
  logic [LANES-1:0] m;

  function automatic logic [31:0] word_at(input logic [31:0] ad);
    return (ad * 32'h9E3779B1) ^ 32'hA5A50F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // memory model: records fetches, returns sectors in order
  always @(negedge clk) begin
    if (resp_valid) rsp_ptr++;
    resp_valid = 1'b0;
    if (rsp_ptr < got_n && (!stall_mode || ($urandom % 3 != 0))) begin
      resp_valid = 1'b1;
      for (int k = 0; k < 8; k++)
        resp_data[32*k +: 32] = word_at(got_fetch[rsp_ptr % 256] + 32'(4*k));
    end
    fetch_ready = stall_mode ? ($urandom % 4 != 0) : 1'b1;
    if (fetch_valid && fetch_ready) begin
      got_fetch[got_n % 256] = fetch_addr;
      got_n++;
    end
  end

  task automatic run_req(input string tag, input int exp_override);
    logic [31:0] exp_list [LANES];
    int exp_n = 0;
    bit bad = 1'b0;
    int act_lanes = 0;
    int start_n;
    bit seq_ok;
    bit data_ok;
    logic [31:0] exp_w;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        act_lanes++;
        if (a[i][1:0] != 2'b00) bad = 1'b1;
      end
    end
    if (!bad) begin
      for (int i = 0; i < LANES; i++) begin
        if (m[i]) begin
          bit dup = 1'b0;
          for (int j = 0; j < exp_n; j++) if (exp_list[j] == {a[i][31:5], 5'b0}) dup = 1'b1;
          if (!dup) begin exp_list[exp_n] = {a[i][31:5], 5'b0}; exp_n++; end
        end
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start_n = got_n;
    for (int i = 0; i < LANES; i++) req_addr[32*i +: 32] = a[i];
    req_mask = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R9", {tag, " busy after accept"}, req_ready, 0);
    while (!done) @(negedge clk);
    check(err == bad, "R7", {tag, " err"}, err, bad);
    check(sector_count == 6'(exp_n), "R2", {tag, " sector_count"}, sector_count, exp_n);
    check(got_n - start_n == exp_n, "R2", {tag, " fetches issued"}, got_n - start_n, exp_n);
    if (exp_override >= 0)
      check(exp_n == exp_override, "R4", {tag, " expected sector total"}, exp_n, exp_override);
    check(useful_bytes == 8'(bad ? 0 : act_lanes * 4), "R9", {tag, " useful_bytes"},
          useful_bytes, bad ? 0 : act_lanes * 4);
    seq_ok = 1'b1;
    for (int j = 0; j < exp_n && j < got_n - start_n; j++)
      if (got_fetch[(start_n + j) % 256] != exp_list[j]) seq_ok = 1'b0;
    check(seq_ok, "R3", {tag, " fetch order"}, got_fetch[start_n % 256], exp_list[0]);
    data_ok = 1'b1;
    exp_w = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] e;
      e = (m[i] && !bad) ? word_at(a[i]) : 32'h0;
      if (lane_data[32*i +: 32] != e && data_ok) begin data_ok = 1'b0; exp_w = e; end
    end
    check(data_ok, "R8", {tag, " lane data"}, data_ok, exp_w);
    @(negedge clk);
    check(!done && req_ready, "R9", {tag, " pulse width"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !fetch_valid && !done, "R1", "control after reset",
          {req_ready, fetch_valid, done}, 3'b100);
    check(lane_data == '0 && sector_count == 0 && useful_bytes == 0, "R1", "data after reset",
          sector_count, 0);

    // R4 coalesced
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 32'(4*i);
    m = '1; run_req("R4 contiguous", 4);

    // R5 strided: 32 sectors, 1024 bytes moved
    for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 32'(32*i);
    m = '1; run_req("R5 strided", 32);
    check(sector_count * 32 == 1024, "R5", "bytes fetched", sector_count * 32, 1024);

    // R6 four lanes active
    for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + 32'(64*i);
    for (int i = 0; i < 4; i++) a[i] = 32'h2200 + 32'(4*i);
    m = 32'h0000000F; run_req("R6 four lanes", 1);

    // R6 empty mask
    m = '0; run_req("R6 empty", 0);

    // R7 misaligned active lane
    for (int i = 0; i < LANES; i++) a[i] = 32'h3000 + 32'(4*i);
    a[7] = 32'h301E; m = '1; run_req("R7 misaligned", 0);
    // R7 misaligned inactive lane is ignored
    m = ~(32'h1 << 7); run_req("R7 ignored lane", 4);

    // R10 broadcast and same-sector sharing
    for (int i = 0; i < LANES; i++) a[i] = 32'h5A40;
    m = '1; run_req("R10 same word", 1);
    for (int i = 0; i < LANES; i++) a[i] = 32'h6000 + 32'(4*(i % 8));
    m = '1; run_req("R10 same sector", 1);

    // R3 reversed order: highest sector first
    for (int i = 0; i < LANES; i++) a[i] = 32'h7000 + 32'(4*(31-i));
    m = '1; run_req("R3 reversed", 4);

    // R3 with back-pressure and random responses, random patterns
    stall_mode = 1'b1;
    for (int i = 0; i < LANES; i++) a[i] = 32'h8000 + 32'(32*((i*7) % 32));
    m = '1; run_req("R3 stalled permuted", 32);
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i] = 32'h9000 + ($urandom % 96) * 4;
        if (n % 10 == 9 && i == 5) a[i] = a[i] | 32'h2;
      end
      m = $urandom;
      if (n % 8 == 0) m = '1;
      run_req("R2 random", -1);
    end
    finish_run();
  end

  initial begin
    process::self().srandom(32'd12345);
  end
endmodule